// File: doc/BRIEF.md
# Processor I/O Port with Decaying Input Bits

This block is the 8-bit on-chip I/O port of a small 8-bit processor. A direction register (bus address 0) and a data register (bus address 1) set which bits are driven and to what level. From these the block produces the effective pin levels, the byte returned when the port is read, and a 3-bit banking-control value for an external address decoder. Any other bus address passes straight through to the RAM interface. Writes to addresses 0 and 1 also reach the RAM, but they carry the last byte seen on the data bus rather than the written value.

Bits 4 and 5 have fixed external behaviour. Bit 4 follows a tape-sense input while it is an input. Bit 5 is pulled to 0 while it is an input. Bits 6 and 7 have nothing driving them externally. When one of them stops being driven, it keeps its last level for a programmable number of clock cycles and then reads as 0. A write to the data register restarts the hold timers of both bits, loading the newly written bit values.

Top module: `cpu_io_port`

## Requirements
- R1: After reset the direction and data registers are 0. With tape sense low, a read of address 0 returns 0x00, a read of address 1 returns 0x17, bank_o is 3'b111 and pins_o is 0x00.
- R2: Each pin whose direction bit is 1 equals the data-register bit in the same cycle. Pins 0–3, 6 and 7, when their direction bit is 0, keep the level the pin had in the previous cycle.
- R3: A read of address 0 returns the direction register. A read of address 1 returns bits 0–5 as (data OR NOT dir) AND (pins OR 0x17), so input bits 0, 1, 2 and 4 always read 1.
- R4: bank_o equals bits 2:0 of (data OR NOT dir).
- R5: While direction bit 5 is 0, pin 5 is 0. While direction bit 4 is 0, pin 4 equals tape_sense_i.
- R6: A write to address 0 that clears direction bit 6 or 7 while that bit was 1 captures the data-register bit. While the bit stays an input, it then reads back as the captured level for the FALL_OFF_CYCLES cycles that follow the write's clock edge, and as 0 afterwards.
- R7: A write to address 1 restarts the hold timers of both bits 6 and 7 with the written bit values, whatever the direction bits are.
- R8: During a write to address 0 or 1, ram_wdata_o carries last_bus_i. For any other address it carries wdata_i. ram_we_o follows wr_en_i and ram_addr_o follows addr_i.
- R9: A read of any address above 1 returns ram_rdata_i unchanged.
- R10: Bits 6 and 7 read back as the data-register bit while their direction bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus address |
| wr_en_i | input | 1 | Bus write strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data |
| last_bus_i | input | 8 | Last byte seen on the data bus |
| tape_sense_i | input | 1 | External level sampled on bit 4 |
| ram_rdata_i | input | 8 | Read data from the RAM array |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| bank_o | output | 3 | Banking control for the address decoder |
| pins_o | output | 8 | Effective pin levels |

## Verification
The hardest case to reach is the exact cycle in which a held bit 6 or 7 decays. It needs a held 1 captured by a direction write, followed by a long run with no data-register write, because any such write restarts the timer. Random traffic almost never produces that run. The bench therefore shortens the fall-off delay through the parameter and uses directed sequences: it captures a level, idles while reading, and checks the last cycle that still shows the level and the first cycle that shows 0. Random traffic around these sequences covers the pin hold, the pull-ups and the RAM path.

// File: rtl/cpu_io_port_pkg.sv
package cpu_io_port_pkg;
  localparam int unsigned PORT_W      = 8;
  localparam int unsigned BANK_W      = 3;
  localparam int unsigned FALL_BITS   = 2;
  localparam int unsigned FALL_BASE   = 6;
  localparam int unsigned TAPE_BIT    = 4;
  localparam int unsigned MOTOR_BIT   = 5;
  localparam logic [PORT_W-1:0] PULLUP_MASK = 8'h17;

  typedef struct packed {
    logic load;
    logic level;
  } fall_load_t;
endpackage

// File: rtl/io_port_regs.sv
module io_port_regs
  import cpu_io_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_dir_i,
  input  logic              wr_data_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] data_o,
  output fall_load_t [FALL_BITS-1:0] fall_load_o
);
  logic [PORT_W-1:0] dir_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_dir_i)  dir_q  <= wdata_i;
      if (wr_data_i) data_q <= wdata_i;
    end
  end

  // timer restart: data write always; dir write only on a 1->0 edge
  for (genvar g = 0; g < FALL_BITS; g++) begin : g_trig
    localparam int unsigned B = FALL_BASE + g;
    always_comb begin
      fall_load_o[g].load  = wr_data_i | (wr_dir_i & dir_q[B] & ~wdata_i[B]);
      fall_load_o[g].level = wr_data_i ? wdata_i[B] : data_q[B];
    end
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;
endmodule

// File: rtl/io_port_fall_cell.sv
module io_port_fall_cell #(
  parameter int unsigned CNT_W    = 19,
  parameter int unsigned LOAD_VAL = 350000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             level_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             level_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= CNT_W'(LOAD_VAL);
      held_q <= level_i;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o   = cnt_q;
  assign level_o = held_q & (cnt_q != '0);
endmodule

// File: rtl/io_port_pins.sv
module io_port_pins
  import cpu_io_port_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PORT_W-1:0]    dir_i,
  input  logic [PORT_W-1:0]    data_i,
  input  logic                 tape_i,
  input  logic [FALL_BITS-1:0] fall_lvl_i,
  output logic [PORT_W-1:0]    pins_o,
  output logic [PORT_W-1:0]    port_rd_o,
  output logic [BANK_W-1:0]    bank_o
);
  logic [PORT_W-1:0] pins_q, pins_eff, drive;

  assign drive = data_i | ~dir_i;

  always_comb begin
    pins_eff = (pins_q & ~dir_i) | (data_i & dir_i);
    if (!dir_i[MOTOR_BIT]) pins_eff[MOTOR_BIT] = 1'b0;
    if (!dir_i[TAPE_BIT])  pins_eff[TAPE_BIT]  = tape_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= '0;
    else         pins_q <= pins_eff;
  end

  always_comb begin
    port_rd_o = drive & (pins_eff | PULLUP_MASK);
    for (int g = 0; g < FALL_BITS; g++) begin
      if (!dir_i[FALL_BASE+g]) port_rd_o[FALL_BASE+g] = fall_lvl_i[g];
    end
  end

  assign pins_o = pins_eff;
  assign bank_o = drive[BANK_W-1:0];
endmodule

// File: rtl/cpu_io_port.sv
module cpu_io_port
  import cpu_io_port_pkg::*;
#(
  parameter int unsigned ADDR_W          = 16,
  parameter int unsigned FALL_OFF_CYCLES = 350000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PORT_W-1:0] last_bus_i,
  input  logic              tape_sense_i,
  input  logic [PORT_W-1:0] ram_rdata_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [PORT_W-1:0] ram_wdata_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [PORT_W-1:0] pins_o
);
  localparam int unsigned CNT_W = $clog2(FALL_OFF_CYCLES + 1);

  logic sel_dir, sel_data, sel_port;
  logic [PORT_W-1:0] dir_q, data_q, port_rd;
  fall_load_t [FALL_BITS-1:0] fall_load;
  logic [FALL_BITS-1:0] fall_lvl;
  logic [CNT_W-1:0] fall_cnt [FALL_BITS];
  logic [CNT_W-1:0] fall_cnt_lo, fall_cnt_hi;

  assign sel_dir  = (addr_i == '0);
  assign sel_data = (addr_i == ADDR_W'(1));
  assign sel_port = sel_dir | sel_data;

  io_port_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_dir_i    (wr_en_i & sel_dir),
    .wr_data_i   (wr_en_i & sel_data),
    .wdata_i     (wdata_i),
    .dir_o       (dir_q),
    .data_o      (data_q),
    .fall_load_o (fall_load)
  );

  for (genvar g = 0; g < FALL_BITS; g++) begin : g_fall
    io_port_fall_cell #(
      .CNT_W    (CNT_W),
      .LOAD_VAL (FALL_OFF_CYCLES)
    ) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (fall_load[g].load),
      .level_i (fall_load[g].level),
      .cnt_o   (fall_cnt[g]),
      .level_o (fall_lvl[g])
    );
  end

  assign fall_cnt_lo = fall_cnt[0];
  assign fall_cnt_hi = fall_cnt[FALL_BITS-1];

  io_port_pins u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_i      (dir_q),
    .data_i     (data_q),
    .tape_i     (tape_sense_i),
    .fall_lvl_i (fall_lvl),
    .pins_o     (pins_o),
    .port_rd_o  (port_rd),
    .bank_o     (bank_o)
  );

  assign rdata_o     = sel_dir ? dir_q : (sel_data ? port_rd : ram_rdata_i);
  assign ram_addr_o  = addr_i;
  assign ram_we_o    = wr_en_i;
  assign ram_wdata_o = sel_port ? last_bus_i : wdata_i;
endmodule

// File: rtl/cpu_io_port_chk.sv
module cpu_io_port_chk #(
  parameter int unsigned ADDR_W          = 16,
  parameter int unsigned FALL_OFF_CYCLES = 350000,
  localparam int unsigned CNT_W = $clog2(FALL_OFF_CYCLES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [7:0]        last_bus_i,
  input logic [7:0]        ram_rdata_i,
  input logic [7:0]        ram_wdata_o,
  input logic [7:0]        pins_o,
  input logic [7:0]        dir_q,
  input logic [7:0]        data_q,
  input logic [CNT_W-1:0]  fall_cnt_lo,
  input logic [CNT_W-1:0]  fall_cnt_hi
);
  logic port_wr;
  assign port_wr = wr_en_i && (addr_i <= ADDR_W'(1));

  a_r2_input_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_q[3] && $past(!dir_q[3])) |-> (pins_o[3] == $past(pins_o[3])));

  a_r6_dir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0 && dir_q[6] && !wdata_i[6])
      |=> (fall_cnt_lo == CNT_W'(FALL_OFF_CYCLES)));

  a_r6_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_cnt_hi != '0 && !port_wr) |=> (fall_cnt_hi == $past(fall_cnt_hi) - CNT_W'(1)));

  a_r7_data_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(1))
      |=> (data_q == $past(wdata_i) && fall_cnt_hi == CNT_W'(FALL_OFF_CYCLES)));

  a_r8_ram_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr |-> (ram_wdata_o == last_bus_i));

  a_r9_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > ADDR_W'(1)) |-> (rdata_o == ram_rdata_i));
endmodule

bind cpu_io_port cpu_io_port_chk #(
  .ADDR_W          (ADDR_W),
  .FALL_OFF_CYCLES (FALL_OFF_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .last_bus_i  (last_bus_i),
  .ram_rdata_i (ram_rdata_i),
  .ram_wdata_o (ram_wdata_o),
  .pins_o      (pins_o),
  .dir_q       (dir_q),
  .data_q      (data_q),
  .fall_cnt_lo (fall_cnt_lo),
  .fall_cnt_hi (fall_cnt_hi)
);

// File: tb/cpu_io_port_tb_top.sv
`timescale 1ns/1ps
module cpu_io_port_tb_top;
  localparam int D = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0, last_bus = '0, ram_rd = '0;
  logic        tape = 1'b0;
  logic [7:0]  rdata, ram_wdata, pins;
  logic [15:0] ram_addr;
  logic        ram_we;
  logic [2:0]  bank;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_dir = '0, m_data = '0, m_pq = '0;
  logic [1:0] m_held = '0;
  int         m_cnt [2] = '{0, 0};
  logic [7:0] o_rd, o_pins;

  always #2 clk = ~clk;

  cpu_io_port #(.ADDR_W(16), .FALL_OFF_CYCLES(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .last_bus_i(last_bus), .tape_sense_i(tape),
    .ram_rdata_i(ram_rd), .ram_addr_o(ram_addr), .ram_we_o(ram_we),
    .ram_wdata_o(ram_wdata), .bank_o(bank), .pins_o(pins)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] eff_pins(logic [7:0] d, logic [7:0] dt, logic [7:0] pq, logic tp);
    logic [7:0] p = (pq & ~d) | (dt & d);
    if (!d[5]) p[5] = 1'b0;
    if (!d[4]) p[4] = tp;
    return p;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] p);
    logic [7:0] r = (m_data | ~m_dir) & (p | 8'h17);
    for (int g = 0; g < 2; g++)
      if (!m_dir[6+g]) r[6+g] = m_held[g] && (m_cnt[g] > 0);
    return r;
  endfunction

  task automatic step(input logic [15:0] a, input logic w, input logic [7:0] wd,
                      input logic tp, input logic [7:0] lb, input logic [7:0] rr);
    logic [7:0] p, er;
    @(negedge clk);
    addr = a; we = w; wdata = wd; tape = tp; last_bus = lb; ram_rd = rr;
    #1;
    p  = eff_pins(m_dir, m_data, m_pq, tp);
    er = (a == 0) ? m_dir : (a == 1) ? exp_read(p) : rr;
    o_rd = rdata; o_pins = pins;
    chk((a > 1) ? "R9 read" : "R3 read", rdata, er);
    chk("R2 pins", pins, p);
    chk("R4 bank", {5'd0, bank}, {5'd0, (m_data[2:0] | ~m_dir[2:0])});
    if (w) chk("R8 ram wdata", ram_wdata, (a <= 1) ? lb : wd);
    @(posedge clk);
    m_pq = p;
    for (int g = 0; g < 2; g++) if (m_cnt[g] > 0) m_cnt[g]--;
    if (w && a == 0) begin
      for (int g = 0; g < 2; g++)
        if (m_dir[6+g] && !wd[6+g]) begin m_cnt[g] = D; m_held[g] = m_data[6+g]; end
      m_dir = wd;
    end
    if (w && a == 1) begin
      m_data = wd;
      for (int g = 0; g < 2; g++) begin m_cnt[g] = D; m_held[g] = wd[6+g]; end
    end
  endtask

  task automatic rd(input logic [15:0] a);
    step(a, 1'b0, 8'h00, tape, 8'h00, 8'hEE);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(16'd1); chk("R1 port read", o_rd, 8'h17); chk("R1 pins", o_pins, 8'h00);
    chk("R1 bank", {5'd0, bank}, 8'h07);
    rd(16'd0); chk("R1 dir read", o_rd, 8'h00);

    // R10 outputs on bits 6/7
    step(16'd0, 1'b1, 8'hC0, 1'b0, 8'h11, 8'h00);
    step(16'd1, 1'b1, 8'h80, 1'b0, 8'h22, 8'h00);
    rd(16'd1); chk("R10 bits 7:6", {6'd0, o_rd[7:6]}, 8'h02);

    // R6 capture on dir clear, hold D cycles then decay
    step(16'd1, 1'b1, 8'hC0, 1'b0, 8'h33, 8'h00);
    step(16'd0, 1'b1, 8'h00, 1'b0, 8'h44, 8'h00);
    for (int j = 1; j <= D + 1; j++) begin
      rd(16'd1);
      if (j == D)     chk("R6 last held", {6'd0, o_rd[7:6]}, 8'h03);
      if (j == D + 1) chk("R6 decayed",   {6'd0, o_rd[7:6]}, 8'h00);
    end

    // R7 data write restarts timers with written bits while inputs
    step(16'd1, 1'b1, 8'h40, 1'b0, 8'h55, 8'h00);
    rd(16'd1); chk("R7 restart", {6'd0, o_rd[7:6]}, 8'h01);

    // R5 tape sense and bit 5 pull-down
    tape = 1'b1;
    rd(16'd1); chk("R5 tape pin", {7'd0, o_pins[4]}, 8'h01);
    chk("R5 motor pin", {7'd0, o_pins[5]}, 8'h00);
    chk("R3 pullup bits", o_rd & 8'h17, 8'h17);

    // R8 port write sends last bus byte, R9 pass-through
    step(16'd0, 1'b1, 8'h55, 1'b0, 8'hA3, 8'h00);
    chk("R8 dir write ram data", ram_wdata, 8'hA3);
    step(16'h1234, 1'b1, 8'h66, 1'b0, 8'hA3, 8'h5A);
    chk("R8 other write ram data", ram_wdata, 8'h66);
    step(16'h1234, 1'b0, 8'h00, 1'b0, 8'h00, 8'h5A);
    chk("R9 pass", o_rd, 8'h5A);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned k = $urandom % 8;
      logic [15:0] a = (k < 3) ? 16'd0 : (k < 6) ? 16'd1 : 16'($urandom_range(65535, 2));
      logic w = ($urandom % 4) == 0;
      step(a, w, 8'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule